// File: doc/BRIEF.md
# Multi-mode DMA address generator

This block produces the source and destination addresses for one DMA channel. A transfer is a block made of frames, and each frame is made of elements. A start pulse captures the base addresses, the element and frame counts, two signed 16-bit indices, an element size code and the addressing mode of each side. From then on, each `advance` strobe moves both addresses on by one element. At every frame boundary an extra per-side frame step is added. The block keeps element and frame counters and gives single-cycle event pulses for half frame, end of frame, entry into the last frame and end of block.

Each side picks one of four addressing modes: constant, post-increment, single-index or double-index. The element stride and the frame stride come from the element size and the two indices. The block also drives the write side of the element move. In fill mode the source is never read and a 32-bit colour value is written. In keyed mode a write is suppressed when the data equals the colour. The low 16 bits of the destination address are exported as a progress count.

Top module: `dma_addr_gen`

## Requirements
- R1: The element size in bytes is 1 << `size_code`. Code 3 is illegal and is used as 4 bytes.
- R2: Mode 0 (constant) keeps an address fixed across elements and frames.
- R3: Mode 1 (post-increment) adds the element size after each element and adds nothing extra at a frame end.
- R4: Mode 2 (single-index) adds size + `elem_idx` − 1 after each element, with `elem_idx` a signed 16-bit value, and adds nothing extra at a frame end.
- R5: Mode 3 (double-index) uses the same element step as R4. At the end of each frame it also adds `frame_idx` − `elem_idx`, both signed 16-bit values.
- R6: `mode_ctl[13:12]` selects the source mode and `mode_ctl[15:14]` selects the destination mode, using the encoding of R2 to R5.
- R7: Each accepted advance increments `elem_pos`. When `elem_pos` reaches the element count it wraps to 0 and `frame_pos` increments. After frames × elements advances, `busy` falls and `ev_block_end` pulses.
- R8: A start with an element count of 0 or a frame count of 0 is rejected. `busy` stays low and the addresses keep their values.
- R9: `ev_half` pulses in the cycle after the advance that makes the number of elements done in the frame equal floor(count/2), provided that value is non-zero.
- R10: `ev_frame_end` pulses in the cycle after the advance that completes a frame. `ev_last_frame` pulses when only the final frame remains, which includes right after a start with a frame count of 1.
- R11: When `fill_en` is 1, `src_rd_en` is 0 and `wr_data` is `color`.
- R12: When `keyed_en` is 1 and the write data equals `color`, `wr_en` stays 0. Otherwise `wr_en` follows an accepted advance.
- R13: `progress` equals the low 16 bits of `dst_addr`.
- R14: `advance` while idle changes no address or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin a block |
| advance | input | 1 | One element moved |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| elem_cfg | input | 16 | Elements per frame |
| frame_cfg | input | 16 | Frames per block |
| elem_idx | input | 16 | Signed element index |
| frame_idx | input | 16 | Signed frame index |
| size_code | input | 2 | Element size code |
| mode_ctl | input | 4 | Bits 15:12: destination mode [15:14], source mode [13:12] |
| fill_en | input | 1 | Constant-fill mode |
| keyed_en | input | 1 | Colour-keyed transparent copy |
| color | input | 32 | Fill and key colour |
| rd_data | input | 32 | Data read from the source |
| busy | output | 1 | Block in progress |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| elem_pos | output | 16 | Element position in the frame |
| frame_pos | output | 16 | Frame position in the block |
| progress | output | 16 | Low half of the destination address |
| ev_half | output | 1 | Half-frame pulse |
| ev_frame_end | output | 1 | End-of-frame pulse |
| ev_last_frame | output | 1 | Last-frame-entered pulse |
| ev_block_end | output | 1 | End-of-block pulse |
| src_rd_en | output | 1 | Source read required |
| wr_data | output | 32 | Data to write |
| wr_en | output | 1 | Write allowed for this element |

## Verification
The bench targets these corner cases:
- **Negative indices in double-index mode.** The per-frame correction is negative there. A design that treats the indices as unsigned would land far above the expected address.
- **Size code 3.** A design that shifts blindly would step 8 bytes instead of 4.
- **Zero element or frame count.** A design that accepts such a start would go busy and never finish.
- **Event timing.** The bench walks a full two-frame block one advance at a time. An off-by-one counter would move the half, frame-end and last-frame pulses by a cycle or drop the block end.
- **Fill and key paths.** Each is checked while an advance is active, so a swapped colour comparison or a read left enabled during fill would show up.

// File: rtl/dag_pkg.sv
`timescale 1ns/1ps
package dag_pkg;

    typedef enum logic [1:0] {
        AM_CONST  = 2'd0,
        AM_POST   = 2'd1,
        AM_SINGLE = 2'd2,
        AM_DOUBLE = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic half;
        logic frame_end;
        logic last_frame;
        logic block_end;
    } dag_events_t;

    localparam int STEP_W = 18;

    // element size in bytes; the illegal code is clamped to 4 bytes
    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        logic [2:0] r;
        if (code == 2'd3) r = 3'd4;
        else              r = 3'(3'd1 << code);
        return r;
    endfunction

    function automatic logic signed [STEP_W-1:0] sext_idx(input logic [15:0] v);
        logic signed [STEP_W-1:0] r;
        r = {{(STEP_W-16){v[15]}}, v};
        return r;
    endfunction

    function automatic logic signed [STEP_W-1:0] elem_step(
        input addr_mode_e m, input logic [1:0] code, input logic [15:0] ei);
        logic signed [STEP_W-1:0] b;
        logic signed [STEP_W-1:0] r;
        b = {{(STEP_W-3){1'b0}}, elem_bytes(code)};
        case (m)
            AM_CONST:  r = '0;
            AM_POST:   r = b;
            default:   r = b + sext_idx(ei) - 18'sd1;
        endcase
        return r;
    endfunction

    function automatic logic signed [STEP_W-1:0] frame_step(
        input addr_mode_e m, input logic [15:0] ei, input logic [15:0] fi);
        logic signed [STEP_W-1:0] r;
        if (m == AM_DOUBLE) r = sext_idx(fi) - sext_idx(ei);
        else                r = '0;
        return r;
    endfunction

endpackage

// File: rtl/dag_addr_lane.sv
`timescale 1ns/1ps
module dag_addr_lane
    import dag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  addr_mode_e    mode,
    input  logic [1:0]    size_code,
    input  logic [15:0]   eidx,
    input  logic [15:0]   fidx,
    input  logic          step_en,
    input  logic          wrap,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - STEP_W;

    logic signed [STEP_W-1:0] es_n, fs_n;
    logic [AW-1:0] es_q, fs_q;

    always_comb begin
        es_n = elem_step(mode, size_code, eidx);
        fs_n = frame_step(mode, eidx, fidx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            es_q <= '0;
            fs_q <= '0;
        end else if (load) begin
            addr <= base;
            es_q <= {{EXT{es_n[STEP_W-1]}}, es_n};
            fs_q <= {{EXT{fs_n[STEP_W-1]}}, fs_n};
        end else if (step_en) begin
            addr <= addr + es_q + (wrap ? fs_q : '0);
        end
    end
endmodule

// File: rtl/dag_seq.sv
`timescale 1ns/1ps
module dag_seq
    import dag_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ok,
    input  logic          adv_ok,
    input  logic [CW-1:0] elem_cfg,
    input  logic [CW-1:0] frame_cfg,
    output logic [CW-1:0] elem_pos,
    output logic [CW-1:0] frame_pos,
    output logic          wrap,
    output logic          last,
    output dag_events_t   ev
);
    localparam int CW1 = CW + 1;

    logic [CW-1:0] elim, flim;
    logic [CW1-1:0] e_next, f_next, f_next2, half_pt;
    logic half_hit;

    always_comb begin
        e_next   = {1'b0, elem_pos} + CW1'(1);
        f_next   = {1'b0, frame_pos} + CW1'(1);
        f_next2  = {1'b0, frame_pos} + CW1'(2);
        half_pt  = {1'b0, elim} >> 1;
        wrap     = (e_next == {1'b0, elim});
        last     = (f_next == {1'b0, flim});
        half_hit = (e_next == half_pt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_pos  <= '0;
            frame_pos <= '0;
            elim      <= '0;
            flim      <= '0;
            ev        <= '0;
        end else begin
            ev <= '0;
            if (start_ok) begin
                elem_pos      <= '0;
                frame_pos     <= '0;
                elim          <= elem_cfg;
                flim          <= frame_cfg;
                ev.last_frame <= (frame_cfg == CW'(1));
            end else if (adv_ok) begin
                ev.half       <= half_hit;
                ev.frame_end  <= wrap;
                ev.last_frame <= wrap && (f_next2 == {1'b0, flim});
                ev.block_end  <= wrap && last;
                if (wrap) begin
                    elem_pos  <= '0;
                    frame_pos <= last ? '0 : f_next[CW-1:0];
                end else begin
                    elem_pos  <= e_next[CW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/dag_wr_ctl.sv
`timescale 1ns/1ps
module dag_wr_ctl #(
    parameter int DW = 32
) (
    input  logic          busy,
    input  logic          xfer,
    input  logic          fill_en,
    input  logic          keyed_en,
    input  logic [DW-1:0] color,
    input  logic [DW-1:0] rd_data,
    output logic          src_rd_en,
    output logic [DW-1:0] wr_data,
    output logic          wr_en
);
    always_comb begin
        src_rd_en = busy && !fill_en;
        wr_data   = fill_en ? color : rd_data;
        wr_en     = xfer && !(keyed_en && (wr_data == color));
    end
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          advance,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] elem_cfg,
    input  logic [CW-1:0] frame_cfg,
    input  logic [15:0]   elem_idx,
    input  logic [15:0]   frame_idx,
    input  logic [1:0]    size_code,
    input  logic [15:12]  mode_ctl,
    input  logic          fill_en,
    input  logic          keyed_en,
    input  logic [DW-1:0] color,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] elem_pos,
    output logic [CW-1:0] frame_pos,
    output logic [PW-1:0] progress,
    output logic          ev_half,
    output logic          ev_frame_end,
    output logic          ev_last_frame,
    output logic          ev_block_end,
    output logic          src_rd_en,
    output logic [DW-1:0] wr_data,
    output logic          wr_en
);
    localparam int NSIDE = 2;

    logic        start_ok, adv_ok, wrap, last;
    dag_events_t ev;

    logic [AW-1:0] base_arr [NSIDE];
    logic [AW-1:0] addr_arr [NSIDE];
    addr_mode_e    mode_arr [NSIDE];

    always_comb begin
        start_ok    = start && (elem_cfg != '0) && (frame_cfg != '0);
        adv_ok      = advance && busy && !start;
        base_arr[0] = src_base;
        base_arr[1] = dst_base;
        mode_arr[0] = addr_mode_e'(mode_ctl[13:12]);
        mode_arr[1] = addr_mode_e'(mode_ctl[15:14]);
    end

    always_ff @(posedge clk) begin
        if (rst)                  busy <= 1'b0;
        else if (start_ok)        busy <= 1'b1;
        else if (adv_ok && wrap && last) busy <= 1'b0;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_lane
        dag_addr_lane #(.AW(AW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .load      (start_ok),
            .base      (base_arr[g]),
            .mode      (mode_arr[g]),
            .size_code (size_code),
            .eidx      (elem_idx),
            .fidx      (frame_idx),
            .step_en   (adv_ok),
            .wrap      (wrap),
            .addr      (addr_arr[g])
        );
    end

    dag_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .adv_ok    (adv_ok),
        .elem_cfg  (elem_cfg),
        .frame_cfg (frame_cfg),
        .elem_pos  (elem_pos),
        .frame_pos (frame_pos),
        .wrap      (wrap),
        .last      (last),
        .ev        (ev)
    );

    dag_wr_ctl #(.DW(DW)) u_wr (
        .busy      (busy),
        .xfer      (adv_ok),
        .fill_en   (fill_en),
        .keyed_en  (keyed_en),
        .color     (color),
        .rd_data   (rd_data),
        .src_rd_en (src_rd_en),
        .wr_data   (wr_data),
        .wr_en     (wr_en)
    );

    always_comb begin
        src_addr      = addr_arr[0];
        dst_addr      = addr_arr[1];
        progress      = addr_arr[1][PW-1:0];
        ev_half       = ev.half;
        ev_frame_end  = ev.frame_end;
        ev_last_frame = ev.last_frame;
        ev_block_end  = ev.block_end;
    end
endmodule

// File: rtl/dag_checker.sv
`timescale 1ns/1ps
module dag_checker #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [CW-1:0] elem_cfg,
    input logic [CW-1:0] frame_cfg,
    input logic          busy,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic [CW-1:0] elem_pos,
    input logic          ev_frame_end,
    input logic          ev_block_end,
    input logic          fill_en,
    input logic          keyed_en,
    input logic [DW-1:0] color,
    input logic [DW-1:0] rd_data,
    input logic          src_rd_en,
    input logic          wr_en
);
    p_reject_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (elem_cfg == '0 || frame_cfg == '0)) |=> (!busy && $stable(src_addr)));

    p_block_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
        ev_block_end |-> (ev_frame_end && !busy));

    p_frame_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        ev_frame_end |-> (elem_pos == '0));

    p_fill_no_read_r11: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !src_rd_en);

    p_key_suppress_r12: assert property (@(posedge clk) disable iff (rst)
        (keyed_en && !fill_en && rd_data == color) |-> !wr_en);

    p_idle_hold_r14: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

bind dma_addr_gen dag_checker #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .elem_cfg     (elem_cfg),
    .frame_cfg    (frame_cfg),
    .busy         (busy),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .elem_pos     (elem_pos),
    .ev_frame_end (ev_frame_end),
    .ev_block_end (ev_block_end),
    .fill_en      (fill_en),
    .keyed_en     (keyed_en),
    .color        (color),
    .rd_data      (rd_data),
    .src_rd_en    (src_rd_en),
    .wr_en        (wr_en)
);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;

    logic clk = 1'b0;
    logic rst, start, advance, fill_en, keyed_en;
    logic [31:0] src_base, dst_base, color, rd_data;
    logic [15:0] elem_cfg, frame_cfg, elem_idx, frame_idx;
    logic [1:0]  size_code;
    logic [15:12] mode_ctl;
    logic busy, ev_half, ev_frame_end, ev_last_frame, ev_block_end, src_rd_en, wr_en;
    logic [31:0] src_addr, dst_addr, wr_data;
    logic [15:0] elem_pos, frame_pos, progress;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dma_addr_gen dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ctl: dst mode [15:14], src mode [13:12]; bases 0x1000 / 0x8000
    typedef struct packed {
        logic [3:0]  ctl;
        logic [1:0]  code;
        logic [15:0] eidx;
        logic [15:0] fidx;
        logic [15:0] ne;
        logic [15:0] nf;
        logic [15:0] nadv;
        logic [31:0] xs;
        logic [31:0] xd;
        logic [15:0] xe;
        logic [15:0] xf;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // R3 post-increment both sides, 4-byte elements
        '{4'h5, 2'd2, 16'd0,    16'd0,    16'd4, 16'd3, 16'd5, 32'h1014, 32'h8014, 16'd1, 16'd1},
        // R2 constant both sides
        '{4'h0, 2'd0, 16'd0,    16'd0,    16'd2, 16'd4, 16'd6, 32'h1000, 32'h8000, 16'd0, 16'd3},
        // R4 single-index source, post-increment destination, 2-byte
        '{4'h6, 2'd1, 16'd3,    16'd0,    16'd3, 16'd2, 16'd4, 32'h1010, 32'h8008, 16'd1, 16'd1},
        // R5 double-index source, constant destination, 1-byte
        '{4'h3, 2'd0, 16'd2,    16'd10,   16'd3, 16'd3, 16'd4, 32'h1010, 32'h8000, 16'd1, 16'd1},
        // R1 code 3 as 4 bytes; R5 negative indices on destination; R6 fields
        '{4'hD, 2'd3, 16'hFFFD, 16'hFFF0, 16'd2, 16'd3, 16'd4, 32'h1010, 32'h7FE6, 16'd0, 16'd2},
        // R4 single-index on both sides
        '{4'hA, 2'd1, 16'd5,    16'd0,    16'd5, 16'd1, 16'd3, 32'h1012, 32'h8012, 16'd3, 16'd0}
    };

    task automatic begin_block(input logic [3:0] ctl, input logic [1:0] code,
                               input logic [15:0] ei, input logic [15:0] fi,
                               input logic [15:0] ne, input logic [15:0] nf);
        mode_ctl  = ctl;
        size_code = code;
        elem_idx  = ei;
        frame_idx = fi;
        elem_cfg  = ne;
        frame_cfg = nf;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; advance = 1'b0; fill_en = 1'b0; keyed_en = 1'b0;
        src_base = 32'h1000; dst_base = 32'h8000; color = 32'h0; rd_data = 32'h0;
        elem_cfg = 16'd0; frame_cfg = 16'd0; elem_idx = 16'd0; frame_idx = 16'd0;
        size_code = 2'd0; mode_ctl = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("reset busy", 32'(busy), 32'd0);
        chk("reset src_addr", src_addr, 32'h0);
        chk("reset events", 32'({ev_half, ev_frame_end, ev_last_frame, ev_block_end}), 32'd0);

        // R8 zero element count, then zero frame count
        begin_block(4'h5, 2'd0, 16'd0, 16'd0, 16'd0, 16'd3);
        chk("R8 zero elements busy", 32'(busy), 32'd0);
        chk("R8 zero elements src_addr", src_addr, 32'h0);
        begin_block(4'h5, 2'd0, 16'd0, 16'd0, 16'd3, 16'd0);
        chk("R8 zero frames busy", 32'(busy), 32'd0);
        chk("R8 zero frames dst_addr", dst_addr, 32'h0);

        // R14 advance while idle
        advance = 1'b1;
        repeat (3) @(negedge clk);
        advance = 1'b0;
        @(negedge clk);
        chk("R14 idle src_addr", src_addr, 32'h0);
        chk("R14 idle elem_pos", 32'(elem_pos), 32'd0);

        // table of address-mode vectors (R1..R6, R13)
        for (int v = 0; v < NV; v++) begin
            begin_block(VECS[v].ctl, VECS[v].code, VECS[v].eidx, VECS[v].fidx,
                        VECS[v].ne, VECS[v].nf);
            for (int k = 0; k < int'(VECS[v].nadv); k++) begin
                advance = 1'b1;
                @(negedge clk);
            end
            advance = 1'b0;
            @(negedge clk);
            chk($sformatf("R6 vec%0d src_addr", v), src_addr, VECS[v].xs);
            chk($sformatf("R6 vec%0d dst_addr", v), dst_addr, VECS[v].xd);
            chk($sformatf("R7 vec%0d elem_pos", v), 32'(elem_pos), 32'(VECS[v].xe));
            chk($sformatf("R7 vec%0d frame_pos", v), 32'(frame_pos), 32'(VECS[v].xf));
            chk($sformatf("R13 vec%0d progress", v), 32'(progress), 32'(VECS[v].xd[15:0]));
            chk($sformatf("R7 vec%0d busy", v), 32'(busy), 32'd1);
        end

        // R7 R9 R10 event walk: 4 elements x 2 frames
        begin_block(4'h5, 2'd0, 16'd0, 16'd0, 16'd4, 16'd2);
        chk("R10 no last_frame at start of 2 frames", 32'(ev_last_frame), 32'd0);
        for (int k = 1; k <= 8; k++) begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            chk($sformatf("R9 half k=%0d", k), 32'(ev_half), 32'((k % 4) == 2));
            chk($sformatf("R10 frame_end k=%0d", k), 32'(ev_frame_end), 32'((k % 4) == 0));
            chk($sformatf("R10 last_frame k=%0d", k), 32'(ev_last_frame), 32'(k == 4));
            chk($sformatf("R7 block_end k=%0d", k), 32'(ev_block_end), 32'(k == 8));
        end
        chk("R7 busy after block", 32'(busy), 32'd0);

        // R10 single-frame block flags last frame at start
        begin_block(4'h5, 2'd0, 16'd0, 16'd0, 16'd3, 16'd1);
        chk("R10 last_frame single frame", 32'(ev_last_frame), 32'd1);
        @(negedge clk);
        chk("R10 last_frame one pulse", 32'(ev_last_frame), 32'd0);

        // R11 fill, R12 key
        begin_block(4'h5, 2'd0, 16'd0, 16'd0, 16'd10, 16'd1);
        color = 32'hA5A5_5A5A; rd_data = 32'h0000_1234;
        fill_en = 1'b1; keyed_en = 1'b0; advance = 1'b1;
        #1;
        chk("R11 fill src_rd_en", 32'(src_rd_en), 32'd0);
        chk("R11 fill wr_data", wr_data, 32'hA5A5_5A5A);
        chk("R11 fill wr_en", 32'(wr_en), 32'd1);
        @(negedge clk);
        fill_en = 1'b0; keyed_en = 1'b1; rd_data = 32'hA5A5_5A5A;
        #1;
        chk("R12 key match wr_en", 32'(wr_en), 32'd0);
        chk("R11 read enabled without fill", 32'(src_rd_en), 32'd1);
        @(negedge clk);
        rd_data = 32'hA5A5_5A5B;
        #1;
        chk("R12 key miss wr_en", 32'(wr_en), 32'd1);
        chk("R12 key miss wr_data", wr_data, 32'hA5A5_5A5B);
        @(negedge clk);
        advance = 1'b0; keyed_en = 1'b0;
        #1;
        chk("R12 no advance wr_en", 32'(wr_en), 32'd0);
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule